// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block models a serial configuration memory that feeds a fixed bitstream into a programmable target, one bit per bit-clock period. The bitstream is a build-time parameter, sent least significant bit first. An address counter selects the bit on the data output, and the output can be disabled, which models a tri-state pin. The counter steps once per rising edge of the bit clock. In master mode the block makes the bit clock itself by dividing the system clock. In slave mode it takes the bit clock from an input pin.

An active-high enable `oe` lets the stream run. When it is low it acts as an active-low reset: the counter returns to bit 0, the bit clock stops and the stream restarts from the beginning. `cs_n` gates the block while the stream is in progress. When `cs_n` is high the data output is released and the counter holds its value. After the last bit a sticky `done` flag rises and the bit clock stays low. Depending on `DONE_DRIVE`, the data output is then either driven high or released.

Control is a three-state machine:
- `ST_RESET` (the stream is not running) goes to `ST_SHIFT` when `oe` is high.
- `ST_SHIFT` goes to `ST_DONE` on the bit-clock edge that consumes bit `BIT_COUNT-1`.
- Every state returns to `ST_RESET` whenever `oe` is low.

Top module: `cfg_stream_top`

## Requirements
- R1: While `oe` is low, and one clock after it falls, `done`, `dout_en` and `bclk_out` are all 0 and the stream position is bit 0.
- R2: In master mode, with `oe` high, `cs_n` low and `done` clear, `bclk_out` is a square wave with a period of 2*`HALF_CYC` system clocks. Whenever the stream is not running, `bclk_out` is 0.
- R3: Before the first rising bit-clock edge, `dout` shows `IMAGE[0]`. After the k-th rising edge it shows `IMAGE[k]`, so bit 0 is sent first. The target samples each bit on the next rising edge.
- R4: While `cs_n` is high, `dout_en` is 0 and bit-clock edges do not move the stream position. When `cs_n` returns low, the same bit is presented again.
- R5: After exactly `BIT_COUNT` rising edges, `done` is 1, `bclk_out` stays 0, and further bit-clock edges have no effect.
- R6: With `done` set and `cs_n` low, `DONE_DRIVE=1` gives `dout_en=1` and `dout=1`. `DONE_DRIVE=0` gives `dout_en=0`.
- R7: Pulling `oe` low in mid-stream, then raising it again, restarts the stream from `IMAGE[0]` and sends all `BIT_COUNT` bits.
- R8: In slave mode (`MASTER=0`), a rising edge on `bclk_in` advances the stream. `bclk_in` must be held at least one system clock high and one low. `bclk_out` is 0 in this mode.
- R9: Once set, `done` stays set as long as `oe` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| oe | input | 1 | Run enable (high); stream reset (low) |
| cs_n | input | 1 | Active-low select |
| bclk_in | input | 1 | Bit clock from outside (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode), otherwise 0 |
| dout | output | 1 | Current serial data bit |
| dout_en | output | 1 | Data output enable; 0 models high impedance |
| done | output | 1 | Whole bitstream sent |

## Verification
On every cycle the assertions check four things:
- the counter clears after `oe` falls;
- the counter only steps by one or returns to zero, and never passes `BIT_COUNT`;
- the counter is frozen while `cs_n` is high;
- `done` is sticky, and the generated clock is low while idle.

Only the bench scenarios can show the rest: the bit order against `IMAGE`, the exact bit-clock period, the restart after a mid-stream abort, and the data-output level after completion in both `DONE_DRIVE` variants. The slave bit-clock path is also exercised only by the bench.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } stream_state_t;
endpackage

// File: rtl/cfg_clkgen.sv
module cfg_clkgen #(
    parameter bit MASTER   = 1'b1,
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bclk_in,
    output logic bclk_out,
    output logic rise
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [HW-1:0] half_q;
    logic          gen_q;
    logic          src;
    logic          src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
            gen_q  <= 1'b0;
        end else if (!run) begin
            half_q <= '0;
            gen_q  <= 1'b0;
        end else if (half_q == HW'(HALF_CYC - 1)) begin
            half_q <= '0;
            gen_q  <= ~gen_q;
        end else begin
            half_q <= half_q + 1'b1;
        end
    end

    assign src = MASTER ? gen_q : bclk_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    assign rise     = src & ~src_q;
    assign bclk_out = MASTER ? gen_q : 1'b0;

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bclk_out);  // R2
endmodule

// File: rtl/cfg_bitmem.sv
module cfg_bitmem #(
    parameter int                     BIT_COUNT = 16,
    parameter logic [BIT_COUNT-1:0]   IMAGE     = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic [$clog2(BIT_COUNT+1)-1:0] addr,
    output logic bit_o,
    output logic last
);
    localparam int AW = $clog2(BIT_COUNT + 1);

    logic [BIT_COUNT-1:0] shifted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   addr <= '0;
        else if (clr) addr <= '0;
        else if (adv && addr != AW'(BIT_COUNT)) addr <= addr + 1'b1;
    end

    assign shifted = IMAGE >> addr;
    assign bit_o   = shifted[0];
    assign last    = (addr == AW'(BIT_COUNT - 1));

    AST_OE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0));  // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) |-> (addr == $past(addr) + 1'b1 || addr == '0));  // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= AW'(BIT_COUNT));  // R5
endmodule

// File: rtl/cfg_stream_top.sv
module cfg_stream_top #(
    parameter int                   BIT_COUNT  = 16,
    parameter logic [BIT_COUNT-1:0] IMAGE      = 16'hA5C3,
    parameter bit                   MASTER     = 1'b1,
    parameter int                   HALF_CYC   = 2,
    parameter bit                   DONE_DRIVE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe,
    input  logic cs_n,
    input  logic bclk_in,
    output logic bclk_out,
    output logic dout,
    output logic dout_en,
    output logic done
);
    import cfg_stream_pkg::*;

    localparam int AW = $clog2(BIT_COUNT + 1);

    stream_state_t state_q, state_d;
    logic          run, rise, adv, cur_bit, last;
    logic [AW-1:0] addr;

    assign run = oe && !cs_n && (state_q == ST_SHIFT);
    assign adv = run && rise;

    cfg_clkgen #(.MASTER(MASTER), .HALF_CYC(HALF_CYC)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .bclk_in(bclk_in),
        .bclk_out(bclk_out), .rise(rise)
    );

    cfg_bitmem #(.BIT_COUNT(BIT_COUNT), .IMAGE(IMAGE)) u_mem (
        .clk(clk), .rst_n(rst_n), .clr(!oe), .adv(adv),
        .addr(addr), .bit_o(cur_bit), .last(last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!oe) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET: state_d = ST_SHIFT;
                ST_SHIFT: if (adv && last) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_RESET;
            endcase
        end
    end

    always_comb begin
        dout_en = 1'b0;
        dout    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                dout_en = 1'b0;
            end
            ST_SHIFT: begin
                dout_en = !cs_n;
                dout    = cur_bit;
            end
            ST_DONE: begin
                done    = 1'b1;
                dout_en = DONE_DRIVE && !cs_n;
                dout    = DONE_DRIVE;
            end
            default: begin
                dout_en = 1'b0;
            end
        endcase
    end

    AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && oe) |=> $stable(addr));  // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && oe) |=> done);  // R9
endmodule

// File: tb/sim_cfg_stream_top.sv
module sim_cfg_stream_top;
    localparam int   CLK_PERIOD = 10;
    localparam int   NBITS      = 16;
    localparam int   HALF       = 2;
    localparam logic [NBITS-1:0] IMG = 16'hA5C3;

    // entry: [19] oe, [18] cs_n, [17] exp done, [16] exp dout_en,
    //        [15:8] cycles held, [7:0] exp bits captured
    localparam logic [19:0] TBL [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd5,   8'd0},   // R1 held off
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd10,  8'd0},   // R4 deselected
        {1'b1, 1'b0, 1'b1, 1'b1, 8'd100, 8'd16},  // R3 R5 R6 full stream
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd5,   8'd16},  // R4 R9 deselect after done
        {1'b1, 1'b0, 1'b1, 1'b1, 8'd20,  8'd16},  // R5 no further clocks
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd3,   8'd0}    // R1 oe low clears
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oe0 = 1'b0, cs0 = 1'b0;
    logic oe1 = 1'b0, cs1 = 1'b0, bin1 = 1'b0;
    logic bco0, do0, den0, dn0;
    logic bco1, do1, den1, dn1;
    int   checks = 0, errors = 0;
    int   idx = 0;
    int   cyc = 0;
    logic oe_seen = 1'b0, prev_bclk = 1'b0, prev_do = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_stream_top #(.BIT_COUNT(NBITS), .IMAGE(IMG), .MASTER(1'b1),
                     .HALF_CYC(HALF), .DONE_DRIVE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .oe(oe0), .cs_n(cs0), .bclk_in(1'b0),
        .bclk_out(bco0), .dout(do0), .dout_en(den0), .done(dn0)
    );

    cfg_stream_top #(.BIT_COUNT(NBITS), .IMAGE(IMG), .MASTER(1'b0),
                     .HALF_CYC(HALF), .DONE_DRIVE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .oe(oe1), .cs_n(cs1), .bclk_in(bin1),
        .bclk_out(bco1), .dout(do1), .dout_en(den1), .done(dn1)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) oe_seen <= oe0;

    // target model: bit present before each rising bit-clock edge is captured
    always @(negedge clk) begin
        if (!oe_seen) begin
            idx = 0;
        end else if (bco0 && !prev_bclk) begin
            if (idx < NBITS) chk("R3 captured bit", int'(prev_do), int'(IMG[idx]));
            else             chk("R5 extra bit clock", idx, NBITS - 1);
            idx++;
        end
        prev_bclk = bco0;
        prev_do   = do0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset done", int'(dn0), 0);
        chk("R1 reset dout_en", int'(den0), 0);
        chk("R1 reset bclk", int'(bco0), 0);

        for (int i = 0; i < 6; i++) begin
            oe0 = TBL[i][19];
            cs0 = TBL[i][18];
            repeat (int'(TBL[i][15:8])) @(negedge clk);
            chk($sformatf("R5 R9 done phase %0d", i), int'(dn0), int'(TBL[i][17]));
            chk($sformatf("R4 R6 dout_en phase %0d", i), int'(den0), int'(TBL[i][16]));
            chk($sformatf("R3 bit count phase %0d", i), idx, int'(TBL[i][7:0]));
            if (TBL[i][17] && TBL[i][16]) chk("R6 dout high after done", int'(do0), 1);
            if (TBL[i][17]) chk("R5 clock low after done", int'(bco0), 0);
        end

        // R2: bit clock period
        oe0 = 1'b1; cs0 = 1'b0;
        n = 0;
        while (!bco0 && n < 50) begin @(negedge clk); n++; end
        while (bco0 && n < 50)  begin @(negedge clk); n++; end
        n = 0;
        while (!bco0 && n < 50) begin @(negedge clk); n++; end
        while (bco0 && n < 50)  begin @(negedge clk); n++; end
        chk("R2 bit clock period", n, 2 * HALF);

        // R7: abort mid-stream and restart
        n = 0;
        while (idx < 6 && n < 200) begin @(negedge clk); n++; end
        oe0 = 1'b0;
        @(negedge clk);
        chk("R7 R1 clock stops", int'(bco0), 0);
        chk("R7 R1 dout_en off", int'(den0), 0);
        chk("R7 R1 done clear", int'(dn0), 0);
        @(negedge clk);
        oe0 = 1'b1;
        n = 0;
        while (!dn0 && n < 300) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        chk("R7 full restart count", idx, NBITS);
        chk("R7 done after restart", int'(dn0), 1);

        // R8: slave mode, with R4 deselect in the middle
        oe1 = 1'b1; cs1 = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 slave bclk_out low", int'(bco1), 0);
        for (int k = 0; k < NBITS; k++) begin
            if (k == 5) begin
                cs1 = 1'b1;
                @(negedge clk);
                chk("R4 slave dout_en off", int'(den1), 0);
                bin1 = 1'b1; repeat (2) @(negedge clk);
                bin1 = 1'b0; repeat (2) @(negedge clk);
                cs1 = 1'b0;
                @(negedge clk);
            end
            if (k % 4 == 1 || k == 5) begin
                chk($sformatf("R8 R4 slave bit %0d", k), int'(do1), int'(IMG[k]));
                chk("R8 slave dout_en", int'(den1), 1);
            end else if (do1 != IMG[k]) begin
                chk($sformatf("R8 slave bit %0d", k), int'(do1), int'(IMG[k]));
            end
            bin1 = 1'b1; repeat (2) @(negedge clk);
            bin1 = 1'b0; repeat (2) @(negedge clk);
        end
        chk("R8 R5 slave done", int'(dn1), 1);
        chk("R6 slave released after done", int'(den1), 0);
        bin1 = 1'b1; repeat (2) @(negedge clk);
        bin1 = 1'b0; repeat (2) @(negedge clk);
        chk("R9 slave done holds", int'(dn1), 1);
        oe1 = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 slave done cleared", int'(dn1), 0);
        chk("R1 slave restart bit0", int'(do1), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule